// File: doc/BRIEF.md
# Receive Buffer Descriptor Ring Fetcher

This block walks the consumer side of a circular ring of receive buffer descriptors held in host memory. It reads one 32-bit descriptor at a time through a request/response memory port. It inspects the descriptor's valid flag and offers the buffer address it carries to the receive DMA engine. The consumer index advances each time the DMA engine takes a buffer.

The fetcher has two pacing modes. In the normal mode it reads a descriptor only when the host has published entries past the consumer index. In prefetch mode it always reads the next entry, and the valid flag decides whether the entry can be used. When an entry's valid flag is clear, the fetcher parks until the host writes the producer index, with any value, and then reads the same entry again.

The fetcher also tracks frame boundaries. A good frame marks the current consumer index as the start of the next frame. A bad frame rewinds the consumer index to the recorded start, so the same buffers are handed out again. On every fetch attempt, the number of published but unconsumed entries is compared with a threshold, and a one-cycle low-buffer pulse is raised when the count is short.

Top module: `rx_desc_fetcher`

## Requirements
- R1: During and right after synchronous reset, cons_idx is 0, mem_req_valid is 0, buf_valid is 0 and low_buf is 0; the recorded frame start is 0.
- R2: With prefetch_en low, a descriptor read is started only when cons_idx differs from prod_idx.
- R3: With prefetch_en high, the next descriptor is read whatever prod_idx holds.
- R4: The read address is {base_addr[31:8], 8'h00} + 4 * cons_idx, so the low 8 bits of base_addr are ignored; mem_req_valid and mem_req_addr stay stable until mem_req_ready is seen.
- R5: A descriptor word with bit 0 set is valid; its buffer address is the word with bits 1:0 cleared. It is offered on buf_addr with buf_valid until buf_take, and the take advances cons_idx by one. Buffers are offered in ring order.
- R6: A descriptor with bit 0 clear is not used and cons_idx does not move. No new read is made until prod_wr is pulsed; the same entry is then read again.
- R7: With ring_large low, the ring has 256 entries and cons_idx wraps from 255 to 0. With ring_large high, it has 2048 entries and wraps from 2047 to 0.
- R8: A frame_good pulse records the consumer index of that cycle, after any advance in the same cycle, as the frame start.
- R9: A frame_bad pulse sets cons_idx back to the recorded frame start, and it wins over a simultaneous frame_good. Any buffer being offered is withdrawn, and a descriptor already requested is dropped when its response arrives. The buffers from the frame start onward are then offered again.
- R10: low_buf pulses for exactly one cycle after each fetch attempt for which (prod_idx - cons_idx) mod ring size is below thresh. A re-read after R6 counts as an attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_addr | input | 32 | Ring base address (low 8 bits ignored) |
| ring_large | input | 1 | 0: 256-entry ring, 1: 2048-entry ring |
| prefetch_en | input | 1 | Read ahead without consulting the producer index |
| prod_idx | input | 11 | Host producer index |
| prod_wr | input | 1 | Pulse: host wrote the producer index |
| thresh | input | 11 | Low-buffer threshold |
| frame_good | input | 1 | Pulse: current frame accepted |
| frame_bad | input | 1 | Pulse: current frame rejected |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_addr | output | 32 | Descriptor read address |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Descriptor word returned |
| mem_rsp_data | input | 32 | Descriptor word |
| buf_valid | output | 1 | Buffer address offered to the DMA engine |
| buf_addr | output | 32 | Buffer address |
| buf_take | input | 1 | DMA engine takes the offered buffer |
| cons_idx | output | 11 | Consumer index |
| low_buf | output | 1 | One-cycle low-buffer pulse |

## Verification
The bench uses the default parameters: an 11-bit index, an 8-bit small-ring index and a 32-bit address. Both ring sizes can therefore be selected at run time. A full traversal of the 2048-entry ring takes only about 8k cycles, so the bench drives the consumer across both the 255-to-0 and the 2047-to-0 wraps. It also runs the consumer past entry 256 in the large ring, where no wrap may occur. The base address carries nonzero low bits, so every request also checks that those bits are ignored.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_HOLD,
    ST_STALL
  } fetch_st_t;
endpackage

// File: rtl/rxf_ring_ptr.sv
module rxf_ring_ptr #(
  parameter int IDX_W      = 11,
  parameter int SMALL_LOG2 = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ring_large,
  input  logic             advance,
  input  logic             rewind,
  input  logic             commit,
  input  logic [IDX_W-1:0] prod_idx,
  output logic [IDX_W-1:0] cons_idx,
  output logic [IDX_W-1:0] avail
);
  localparam logic [IDX_W-1:0] SMALL_MASK = IDX_W'((1 << SMALL_LOG2) - 1);
  localparam logic [IDX_W-1:0] LARGE_MASK = '1;

  logic [IDX_W-1:0] mask;
  logic [IDX_W-1:0] cons_q, start_q, cons_inc;

  assign mask     = ring_large ? LARGE_MASK : SMALL_MASK;
  assign cons_inc = (cons_q + 1'b1) & mask;
  assign avail    = (prod_idx - cons_q) & mask;
  assign cons_idx = cons_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cons_q  <= '0;
      start_q <= '0;
    end else begin
      if (rewind)       cons_q <= start_q;
      else if (advance) cons_q <= cons_inc;
      if (commit && !rewind) start_q <= advance ? cons_inc : cons_q;
    end
  end

  // R7: small ring wraps from its last entry to zero
  a_r7_small_wrap: assert property (@(posedge clk) disable iff (rst)
    (advance && !rewind && !ring_large && cons_q == SMALL_MASK) |=> cons_q == '0);
  // R7: large ring wraps from its last entry to zero
  a_r7_large_wrap: assert property (@(posedge clk) disable iff (rst)
    (advance && !rewind && ring_large && cons_q == LARGE_MASK) |=> cons_q == '0);
  // R9: rewind lands on the recorded frame start
  a_r9_rewind: assert property (@(posedge clk) disable iff (rst)
    rewind |=> cons_q == $past(start_q));
endmodule

// File: rtl/rxf_low_watch.sv
module rxf_low_watch #(
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             attempt,
  input  logic [IDX_W-1:0] avail,
  input  logic [IDX_W-1:0] thresh,
  output logic             low_buf
);
  logic low_q;

  always_ff @(posedge clk) begin
    if (rst) low_q <= 1'b0;
    else     low_q <= attempt && (avail < thresh);
  end

  assign low_buf = low_q;

  // R10: the event is a single-cycle pulse
  a_r10_one_cycle: assert property (@(posedge clk) disable iff (rst)
    low_q |=> !low_q);
endmodule

// File: rtl/rxf_fetch_fsm.sv
module rxf_fetch_fsm
  import rxf_pkg::*;
#(
  parameter int IDX_W  = 11,
  parameter int ADDR_W = 32,
  parameter int DESC_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prefetch_en,
  input  logic              ring_has_entries,
  input  logic              prod_wr,
  input  logic              frame_bad,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [IDX_W-1:0]  cons_idx,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic [DESC_W-1:0] mem_rsp_data,
  output logic              buf_valid,
  output logic [ADDR_W-1:0] buf_addr,
  input  logic              buf_take,
  output logic              attempt,
  output logic              advance,
  output logic              rewind
);
  localparam int ALIGN_LSB = 8;
  localparam int PAD_W     = ADDR_W - IDX_W - 2;

  fetch_st_t         state_q, state_d;
  logic              rb_pend_q, rb_pend_d, rb;
  logic              load_buf;
  logic [ADDR_W-1:0] addr_q, buf_q, ring_base, slot_addr;

  assign rb        = frame_bad | rb_pend_q;
  assign ring_base = {base_addr[ADDR_W-1:ALIGN_LSB], {ALIGN_LSB{1'b0}}};
  assign slot_addr = ring_base + {{PAD_W{1'b0}}, cons_idx, 2'b00};

  always_comb begin
    state_d   = state_q;
    rb_pend_d = rb_pend_q | frame_bad;
    attempt   = 1'b0;
    advance   = 1'b0;
    rewind    = 1'b0;
    load_buf  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (rb) begin
          rewind    = 1'b1;
          rb_pend_d = 1'b0;
        end else if (prefetch_en || ring_has_entries) begin
          attempt = 1'b1;
          state_d = ST_REQ;
        end
      end
      ST_REQ: begin
        if (mem_req_ready) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          if (rb) begin
            rewind    = 1'b1;
            rb_pend_d = 1'b0;
            state_d   = ST_IDLE;
          end else if (mem_rsp_data[0]) begin
            load_buf = 1'b1;
            state_d  = ST_HOLD;
          end else begin
            state_d = ST_STALL;
          end
        end
      end
      ST_HOLD: begin
        if (rb) begin
          rewind    = 1'b1;
          rb_pend_d = 1'b0;
          state_d   = ST_IDLE;
        end else if (buf_take) begin
          advance = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_STALL: begin
        if (rb) begin
          rewind    = 1'b1;
          rb_pend_d = 1'b0;
          state_d   = ST_IDLE;
        end else if (prod_wr) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      rb_pend_q <= 1'b0;
      addr_q    <= '0;
      buf_q     <= '0;
    end else begin
      state_q   <= state_d;
      rb_pend_q <= rb_pend_d;
      if (attempt)  addr_q <= slot_addr;
      if (load_buf) buf_q  <= {mem_rsp_data[ADDR_W-1:2], 2'b00};
    end
  end

  assign mem_req_valid = (state_q == ST_REQ);
  assign mem_req_addr  = addr_q;
  assign buf_valid     = (state_q == ST_HOLD);
  assign buf_addr      = buf_q;

  // R4: request held stable until accepted
  a_r4_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  // R5: offered buffer held until taken
  a_r5_buf_hold: assert property (@(posedge clk) disable iff (rst)
    (buf_valid && !buf_take && !frame_bad && !rb_pend_q) |=> (buf_valid && $stable(buf_addr)));
  // R6: a parked fetcher issues nothing until the producer is written
  a_r6_parked: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STALL && !prod_wr && !frame_bad && !rb_pend_q) |=> !mem_req_valid && !buf_valid);
endmodule

// File: rtl/rx_desc_fetcher.sv
module rx_desc_fetcher #(
  parameter int IDX_W      = 11,
  parameter int SMALL_LOG2 = 8,
  parameter int ADDR_W     = 32,
  parameter int DESC_W     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              ring_large,
  input  logic              prefetch_en,
  input  logic [IDX_W-1:0]  prod_idx,
  input  logic              prod_wr,
  input  logic [IDX_W-1:0]  thresh,
  input  logic              frame_good,
  input  logic              frame_bad,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic [DESC_W-1:0] mem_rsp_data,
  output logic              buf_valid,
  output logic [ADDR_W-1:0] buf_addr,
  input  logic              buf_take,
  output logic [IDX_W-1:0]  cons_idx,
  output logic              low_buf
);
  logic [IDX_W-1:0] avail;
  logic             attempt, advance, rewind;

  rxf_ring_ptr #(.IDX_W(IDX_W), .SMALL_LOG2(SMALL_LOG2)) u_ptr (
    .clk(clk), .rst(rst), .ring_large(ring_large),
    .advance(advance), .rewind(rewind), .commit(frame_good),
    .prod_idx(prod_idx), .cons_idx(cons_idx), .avail(avail)
  );

  rxf_fetch_fsm #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .DESC_W(DESC_W)) u_fsm (
    .clk(clk), .rst(rst), .prefetch_en(prefetch_en),
    .ring_has_entries(avail != '0), .prod_wr(prod_wr), .frame_bad(frame_bad),
    .base_addr(base_addr), .cons_idx(cons_idx),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .buf_valid(buf_valid), .buf_addr(buf_addr),
    .buf_take(buf_take), .attempt(attempt), .advance(advance), .rewind(rewind)
  );

  rxf_low_watch #(.IDX_W(IDX_W)) u_low (
    .clk(clk), .rst(rst), .attempt(attempt), .avail(avail),
    .thresh(thresh), .low_buf(low_buf)
  );

  // R2: in normal mode a new read only starts with entries published
  a_r2_gate: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_req_valid) && !$past(prefetch_en)) |-> $past(cons_idx != prod_idx));
endmodule

// File: tb/rx_desc_fetcher_test.sv
module rx_desc_fetcher_test;
  localparam logic [31:0] BASE = 32'h1000_00A5;
  localparam logic [31:0] BUFB = 32'h4000_0000;

  logic        clk = 0;
  logic        rst = 1;
  logic [31:0] base_addr = BASE;
  logic        ring_large = 1, prefetch_en = 0, prod_wr = 0;
  logic [10:0] prod_idx = 0, thresh = 0;
  logic        frame_good = 0, frame_bad = 0;
  logic        mem_req_valid, mem_req_ready = 1, mem_rsp_valid = 0;
  logic [31:0] mem_req_addr, mem_rsp_data = 0;
  logic        buf_valid, buf_take = 1, low_buf;
  logic [31:0] buf_addr;
  logic [10:0] cons_idx;

  int checks = 0, errors = 0, req_cnt = 0, low_cnt = 0;
  bit done = 0;
  logic [31:0] desc [2048];
  logic [31:0] exp_q [$];

  always #5 clk = ~clk;

  rx_desc_fetcher uut (
    .clk(clk), .rst(rst), .base_addr(base_addr), .ring_large(ring_large),
    .prefetch_en(prefetch_en), .prod_idx(prod_idx), .prod_wr(prod_wr),
    .thresh(thresh), .frame_good(frame_good), .frame_bad(frame_bad),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .buf_valid(buf_valid), .buf_addr(buf_addr),
    .buf_take(buf_take), .cons_idx(cons_idx), .low_buf(low_buf)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: one-cycle response, address check (R4)
  always @(posedge clk) begin
    mem_rsp_valid <= mem_req_valid && mem_req_ready;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_data <= desc[mem_req_addr[12:2]];
      check((mem_req_addr & 32'hFFFF_E003) == 32'h1000_0000, "R4 address",
            mem_req_addr, {BASE[31:8], 8'h00});
    end
  end

  // scoreboard monitor (R5)
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_req_valid) req_cnt++;
      if (low_buf) low_cnt++;
      if (buf_valid && buf_take) begin
        if (exp_q.size() == 0) check(0, "R5 unexpected buffer", buf_addr, 0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          check(buf_addr == e, "R5 buffer order", buf_addr, e);
        end
      end
    end
  end

  task automatic expect_run(input int first, input int n, input int mask);
    for (int k = 0; k < n; k++) exp_q.push_back(BUFB + (((first + k) & mask) << 4));
  endtask

  task automatic drain(input string req);
    int t = 0;
    while (exp_q.size() != 0 && t < 20000) begin @(negedge clk); t++; end
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
    repeat (8) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (3) @(negedge clk);
    rst = 0; req_cnt = 0; low_cnt = 0;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1; @(negedge clk); s = 0;
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) desc[i] = BUFB + (i << 4) + 32'h3;
    desc[6] = BUFB + (6 << 4) + 32'h2;   // bit0 clear: invalid
    desc[7] = BUFB + (7 << 4);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cons_idx == 0, "R1 cons_idx", cons_idx, 0);
    check(!mem_req_valid, "R1 mem_req_valid", mem_req_valid, 0);
    check(!buf_valid, "R1 buf_valid", buf_valid, 0);
    check(!low_buf, "R1 low_buf", low_buf, 0);
    rst = 0;
    @(negedge clk);
    check(cons_idx == 0 && !mem_req_valid, "R1 after release", cons_idx, 0);
    // R2: nothing published, no reads
    repeat (20) @(negedge clk);
    check(req_cnt == 0, "R2 idle with empty ring", req_cnt, 0);
    prod_idx = 4; expect_run(0, 4, 2047);
    drain("R2 published entries");
    check(cons_idx == 4, "R2 stop at producer", cons_idx, 4);
    check(req_cnt == 4, "R2 read count", req_cnt, 4);
    pulse(frame_good);                    // R8: start = 4
    // R3 prefetch beyond producer
    prefetch_en = 1; expect_run(4, 2, 2047);
    drain("R3 prefetch reads past producer");
    begin
      int r0;
      r0 = req_cnt;
      repeat (20) @(negedge clk);
      check(req_cnt == r0, "R6 no read while parked", req_cnt, r0);
    end
    check(cons_idx == 6, "R6 cons holds on invalid", cons_idx, 6);
    desc[6] = desc[6] | 32'h1;
    expect_run(6, 1, 2047);
    pulse(prod_wr);
    drain("R6 re-read after producer write");
    check(cons_idx == 7, "R6 parked on next invalid", cons_idx, 7);
    // R9 rewind to frame start recorded by R8
    pulse(frame_bad);
    check(cons_idx == 4, "R8 R9 rewind target", cons_idx, 4);
    expect_run(4, 3, 2047);
    drain("R9 buffers reoffered");
    check(cons_idx == 7, "R9 after replay", cons_idx, 7);
    // R7 large ring
    desc[7] = desc[7] | 32'h1;
    prefetch_en = 0; prod_idx = 0; ring_large = 1;
    do_reset();
    prod_idx = 300; expect_run(0, 300, 2047);
    drain("R7 large ring past 256");
    check(cons_idx == 300, "R7 no wrap at 256 in large ring", cons_idx, 300);
    prod_idx = 2047; expect_run(300, 1747, 2047);
    drain("R7 large fill");
    prod_idx = 2; expect_run(2047, 3, 2047);
    drain("R7 large wrap");
    check(cons_idx == 2, "R7 large wrap index", cons_idx, 2);
    check(low_cnt == 0, "R10 no pulse at zero threshold", low_cnt, 0);
    // R7 small ring
    prod_idx = 0; ring_large = 0;
    do_reset();
    prod_idx = 200; expect_run(0, 200, 255);
    drain("R7 small fill");
    prod_idx = 3; expect_run(200, 59, 255);
    drain("R7 small wrap");
    check(cons_idx == 3, "R7 small wrap index", cons_idx, 3);
    // R10 low-buffer pulses
    prod_idx = 0; ring_large = 1;
    do_reset();
    thresh = 3; prod_idx = 2; expect_run(0, 2, 2047);
    drain("R10 run one");
    check(low_cnt == 2, "R10 pulses with count 2,1", low_cnt, 2);
    prod_idx = 10; expect_run(2, 8, 2047);
    drain("R10 run two");
    check(low_cnt == 4, "R10 pulses only below threshold", low_cnt, 4);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1-wide timeout actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule